// File: doc/BRIEF.md
# Dual-Network Coherence Message Interface

This block sits between one tile's cache and coherence agent and two physically separate on-chip networks. One is narrow (48-bit flits) and carries only request-class traffic. The other is wide (128-bit flits) and carries only response-class traffic. On the transmit side the agent hands over one message at a time. A message has a class, a short or long flag, a destination node, a control word and, for long messages, a 64-byte block. The block turns the message into a packet of flits on the network that matches its class.

On the receive side the block collects flits from both networks and rebuilds complete messages. It hands them to the agent in the order each source injected them. This order holds across the two networks. Every message carries a per-destination sequence number. The sender keeps one such counter for each destination and uses it for both classes. The receiver keeps an expected number for each source. A message that arrives ahead of its turn waits in a small reorder store, which has one slot per source per network. When a slot is occupied and the next message for it completes, that network's input ready is withdrawn until the slot drains.

Top module: `dnet_ni`

## Requirements
- R1: A request-class message (tx_cls = 0) is sent only as flits on the narrow output. The wide output carries none of its flits.
- R2: A response-class message (tx_cls = 1) is sent only as flits on the wide output. The narrow output carries none of its flits.
- R3: Packet lengths are fixed by network and length flag:
  - narrow network: a short message is 2 flits and a long message is 13 flits;
  - wide network: a short message is 1 flit and a long message is 5 flits.
- R4: The header is a 74-bit field vector, with these fields and bit positions:
  - class: bit 0;
  - long flag: bit 1;
  - source: bits 3:2;
  - destination: bits 5:4;
  - sequence: bits 9:6;
  - control: bits 73:10.

  The header is placed least-significant bit first across the header flits (two flits on the narrow network, one on the wide network) and zero-padded up to the end of the header flits.
- R5: A long message's 512-bit block follows the header flits, least-significant bits first, one flit width per flit. The unused top of the last data flit is zero (16 bits on the narrow network).
- R6: Sequence numbers come from one counter per destination. The counter is shared by both classes, starts at 0 after reset and increases by 1 (modulo 16) for each accepted message.
- R7: While a packet is in progress on a network, tx_ready is low for that network's class until the tail flit is accepted, so packets never interleave. The other class can still be accepted. A flit held while its output ready is low stays unchanged.
- R8: A received packet is delivered as one message on the rx outputs. Class, long flag, source, sequence, control and block are recovered. The block reads as zero for short messages.
- R9: Messages from one source are delivered only in sequence order, starting from 0 after reset. A message that arrives early on either network is held and is not delivered until every earlier one from that source has been delivered.
- R10: Each source has one holding slot per network. When a message completes on a network while its source's slot for that network is occupied, that network's input ready stays low until the slot drains. The other network keeps accepting.
- R11: After reset, tx_ready is 1, both output valids are 0, rx_valid is 0 and both input readies are 1.
- R12: Sources are independent. A deliverable message from one source is delivered while another source is waiting for a gap to fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Agent offers a message |
| tx_ready | output | 1 | Message accepted this cycle when valid |
| tx_cls | input | 1 | 0 request, 1 response |
| tx_long | input | 1 | Message carries a block |
| tx_dst | input | 2 | Destination node |
| tx_ctrl | input | 64 | Control word |
| tx_data | input | 512 | Cache block |
| rqo_flit | output | 48 | Narrow network output flit |
| rqo_valid | output | 1 | Narrow output flit valid |
| rqo_ready | input | 1 | Narrow network accepts |
| rso_flit | output | 128 | Wide network output flit |
| rso_valid | output | 1 | Wide output flit valid |
| rso_ready | input | 1 | Wide network accepts |
| rqi_flit | input | 48 | Narrow network input flit |
| rqi_valid | input | 1 | Narrow input flit valid |
| rqi_ready | output | 1 | Narrow input accepted |
| rsi_flit | input | 128 | Wide network input flit |
| rsi_valid | input | 1 | Wide input flit valid |
| rsi_ready | output | 1 | Wide input accepted |
| rx_valid | output | 1 | Delivered message valid |
| rx_ready | input | 1 | Agent takes the message |
| rx_cls | output | 1 | Delivered class |
| rx_long | output | 1 | Delivered long flag |
| rx_src | output | 2 | Delivered source |
| rx_seq | output | 4 | Delivered sequence number |
| rx_ctrl | output | 64 | Delivered control word |
| rx_data | output | 512 | Delivered block |

## Verification
The assertions assume well-behaved networks and senders. Each network delivers a source's packets in injection order and without interleaving. The length flag in a header matches the number of flits that follow it. A source never has more than sixteen messages outstanding, so sequence numbers are not reused. The stimulus respects these assumptions: every packet is built whole in the bench and fed in one flit stream, and only a handful of messages per source are sent. Early arrivals are set up only in arrangements where the missing message can still arrive on the other network.

// File: rtl/dnet_pkg.sv
package dnet_pkg;
  localparam logic CLS_REQ = 1'b0;
  localparam logic CLS_RSP = 1'b1;

  function automatic int unsigned div_up(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // header vector: {ctrl, seq, dst, src, long, cls}
  function automatic int unsigned hdr_bits(int unsigned node_w, int unsigned seq_w,
                                           int unsigned ctrl_w);
    return 2 + 2 * node_w + seq_w + ctrl_w;
  endfunction

  function automatic int unsigned pkt_flits(int unsigned fw, int unsigned hw,
                                            int unsigned bw, logic lng);
    return div_up(hw, fw) + (lng ? div_up(bw, fw) : 0);
  endfunction
endpackage

// File: rtl/dnet_tx_ser.sv
module dnet_tx_ser
  import dnet_pkg::*;
#(
  parameter int FW = 48,
  parameter int HW = 74,
  parameter int BW = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [HW-1:0] ld_hdr,
  input  logic [BW-1:0] ld_data,
  output logic          idle,
  output logic [FW-1:0] out_flit,
  output logic          out_valid,
  input  logic          out_ready
);
  localparam int HF = int'(div_up(HW, FW));
  localparam int DF = int'(div_up(BW, FW));
  localparam int NF = HF + DF;
  localparam int CW = $clog2(NF + 1);

  logic [NF*FW-1:0] shreg_q;
  logic [CW-1:0]    left_q;
  logic [HF*FW-1:0] hpad;
  logic [DF*FW-1:0] dpad;
  logic             step;

  always_comb begin
    hpad = '0;
    hpad[HW-1:0] = ld_hdr;
    dpad = '0;
    dpad[BW-1:0] = ld_data;
  end

  assign idle      = (left_q == '0);
  assign out_valid = !idle;
  assign out_flit  = shreg_q[FW-1:0];
  assign step      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      shreg_q <= '0;
    end else if (ld && idle) begin
      shreg_q <= {dpad, hpad};
      left_q  <= ld_hdr[1] ? CW'(NF) : CW'(HF);
    end else if (step) begin
      shreg_q <= shreg_q >> FW;
      left_q  <= left_q - 1'b1;
    end
  end

  // R7: a flit waiting on the network is held unchanged
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

  // R7: no new packet is loaded while one is still leaving
  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> idle);
endmodule

// File: rtl/dnet_rx_asm.sv
module dnet_rx_asm
  import dnet_pkg::*;
#(
  parameter int FW     = 48,
  parameter int HW     = 74,
  parameter int BW     = 512,
  parameter int NODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     in_flit,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  output logic [HW-1:0]     out_hdr,
  output logic [BW-1:0]     out_data,
  output logic [NODE_W-1:0] out_src,
  input  logic              slot_free
);
  localparam int HF = int'(div_up(HW, FW));
  localparam int DF = int'(div_up(BW, FW));
  localparam int NF = HF + DF;
  localparam int CW = $clog2(NF + 1);

  logic [NF*FW-1:0] acc_q;
  logic [CW-1:0]    cnt_q;
  logic             lng_now, last, take, done;
  logic             unused_pad;

  assign lng_now  = (cnt_q == '0) ? in_flit[1] : acc_q[1];
  assign last     = (cnt_q == (lng_now ? CW'(NF - 1) : CW'(HF - 1)));
  assign in_ready = !out_valid || slot_free;
  assign take     = in_valid && in_ready;
  assign done     = take && last;

  assign out_hdr    = acc_q[HW-1:0];
  assign out_data   = acc_q[HF*FW +: BW] & {BW{acc_q[1]}};
  assign out_src    = acc_q[2 +: NODE_W];
  assign unused_pad = ^acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      out_valid <= 1'b0;
      acc_q     <= '0;
    end else begin
      if (take) begin
        acc_q[cnt_q*FW +: FW] <= in_flit;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      if (done) out_valid <= 1'b1;
      else if (out_valid && slot_free) out_valid <= 1'b0;
    end
  end

  // R10: a finished message with no free slot stays put, unchanged
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !slot_free) |=> (out_valid && $stable(out_hdr)));
endmodule

// File: rtl/dnet_rob.sv
module dnet_rob #(
  parameter int NODE_W = 2,
  parameter int SEQ_W  = 4,
  parameter int HW     = 74,
  parameter int BW     = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             wr_valid,
  input  logic [1:0][NODE_W-1:0] wr_src,
  input  logic [1:0][HW-1:0]     wr_hdr,
  input  logic [1:0][BW-1:0]     wr_data,
  output logic [1:0]             slot_free,
  output logic                   rx_valid,
  input  logic                   rx_ready,
  output logic [HW-1:0]          rx_hdr,
  output logic [BW-1:0]          rx_data
);
  localparam int NS    = 1 << NODE_W;
  localparam int NSL   = 2 * NS;
  localparam int IW    = NODE_W + 1;
  localparam int SQ_LO = 2 + 2 * NODE_W;

  logic [NSL-1:0]            vld_q;
  logic [HW-1:0]             hdr_q [NSL];
  logic [BW-1:0]             dat_q [NSL];
  logic [NS-1:0][SEQ_W-1:0]  exp_q;
  logic [IW-1:0]             wr_idx [2];
  logic [1:0]                wr_en;
  logic [NSL-1:0]            due;
  logic [IW-1:0]             sel;
  logic                      any, pop;

  always_comb begin
    for (int n = 0; n < 2; n++) begin
      wr_idx[n]    = {wr_src[n], 1'(n)};
      slot_free[n] = !vld_q[wr_idx[n]];
      wr_en[n]     = wr_valid[n] && slot_free[n];
    end
  end

  // lowest slot index wins among messages whose turn has come
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NSL - 1; i >= 0; i--) begin
      due[i] = vld_q[i] && (hdr_q[i][SQ_LO +: SEQ_W] == exp_q[i >> 1]);
      if (due[i]) begin
        sel = IW'(i);
        any = 1'b1;
      end
    end
  end

  assign rx_valid = any;
  assign rx_hdr   = hdr_q[sel];
  assign rx_data  = dat_q[sel];
  assign pop      = any && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      exp_q <= '0;
    end else begin
      if (pop) begin
        vld_q[sel] <= 1'b0;
        exp_q[sel[IW-1:1]] <= exp_q[sel[IW-1:1]] + 1'b1;
      end
      for (int n = 0; n < 2; n++)
        if (wr_en[n]) vld_q[wr_idx[n]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < 2; n++) begin
      if (wr_en[n]) begin
        hdr_q[wr_idx[n]] <= wr_hdr[n];
        dat_q[wr_idx[n]] <= wr_data[n];
      end
    end
  end

  // R9: expected sequence numbers move only when a message is delivered
  assert_exp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(exp_q));
endmodule

// File: rtl/dnet_ni.sv
module dnet_ni
  import dnet_pkg::*;
#(
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 0,
  parameter int SEQ_W   = 4,
  parameter int CTRL_W  = 64,
  parameter int BLK_W   = 512,
  parameter int RQ_FW   = 48,
  parameter int RS_FW   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              tx_cls,
  input  logic              tx_long,
  input  logic [NODE_W-1:0] tx_dst,
  input  logic [CTRL_W-1:0] tx_ctrl,
  input  logic [BLK_W-1:0]  tx_data,
  output logic [RQ_FW-1:0]  rqo_flit,
  output logic              rqo_valid,
  input  logic              rqo_ready,
  output logic [RS_FW-1:0]  rso_flit,
  output logic              rso_valid,
  input  logic              rso_ready,
  input  logic [RQ_FW-1:0]  rqi_flit,
  input  logic              rqi_valid,
  output logic              rqi_ready,
  input  logic [RS_FW-1:0]  rsi_flit,
  input  logic              rsi_valid,
  output logic              rsi_ready,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_cls,
  output logic              rx_long,
  output logic [NODE_W-1:0] rx_src,
  output logic [SEQ_W-1:0]  rx_seq,
  output logic [CTRL_W-1:0] rx_ctrl,
  output logic [BLK_W-1:0]  rx_data
);
  localparam int HW    = int'(hdr_bits(NODE_W, SEQ_W, CTRL_W));
  localparam int NN    = 1 << NODE_W;
  localparam int SQ_LO = 2 + 2 * NODE_W;
  localparam logic [NODE_W-1:0] MY_ID = NODE_W'(NODE_ID);

  // ---------------- transmit ----------------
  logic [SEQ_W-1:0] seq_q [NN];
  logic [HW-1:0]    tx_hdr;
  logic             rq_idle, rs_idle, tx_acc, ld_rq, ld_rs;

  assign tx_ready = (tx_cls == CLS_RSP) ? rs_idle : rq_idle;
  assign tx_acc   = tx_valid && tx_ready;
  assign ld_rq    = tx_acc && (tx_cls == CLS_REQ);
  assign ld_rs    = tx_acc && (tx_cls == CLS_RSP);
  assign tx_hdr   = {tx_ctrl, seq_q[tx_dst], tx_dst, MY_ID, tx_long, tx_cls};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < NN; d++) seq_q[d] <= '0;
    end else if (tx_acc) begin
      seq_q[tx_dst] <= seq_q[tx_dst] + 1'b1;
    end
  end

  dnet_tx_ser #(.FW(RQ_FW), .HW(HW), .BW(BLK_W)) u_ser_rq (
    .clk(clk), .rst_n(rst_n), .ld(ld_rq), .ld_hdr(tx_hdr), .ld_data(tx_data),
    .idle(rq_idle), .out_flit(rqo_flit), .out_valid(rqo_valid), .out_ready(rqo_ready));

  dnet_tx_ser #(.FW(RS_FW), .HW(HW), .BW(BLK_W)) u_ser_rs (
    .clk(clk), .rst_n(rst_n), .ld(ld_rs), .ld_hdr(tx_hdr), .ld_data(tx_data),
    .idle(rs_idle), .out_flit(rso_flit), .out_valid(rso_valid), .out_ready(rso_ready));

  // R1: an accepted request starts leaving on the narrow network
  assert_req_net_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && tx_cls == CLS_REQ) |=> rqo_valid);

  // R2: an accepted response starts leaving on the wide network
  assert_rsp_net_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && tx_cls == CLS_RSP) |=> rso_valid);

  // ---------------- receive ----------------
  logic [1:0]             a_valid, a_free;
  logic [1:0][HW-1:0]     a_hdr;
  logic [1:0][BLK_W-1:0]  a_data;
  logic [1:0][NODE_W-1:0] a_src;
  logic [HW-1:0]          rx_hdr;
  logic                   unused_dst;

  dnet_rx_asm #(.FW(RQ_FW), .HW(HW), .BW(BLK_W), .NODE_W(NODE_W)) u_asm_rq (
    .clk(clk), .rst_n(rst_n), .in_flit(rqi_flit), .in_valid(rqi_valid), .in_ready(rqi_ready),
    .out_valid(a_valid[0]), .out_hdr(a_hdr[0]), .out_data(a_data[0]), .out_src(a_src[0]),
    .slot_free(a_free[0]));

  dnet_rx_asm #(.FW(RS_FW), .HW(HW), .BW(BLK_W), .NODE_W(NODE_W)) u_asm_rs (
    .clk(clk), .rst_n(rst_n), .in_flit(rsi_flit), .in_valid(rsi_valid), .in_ready(rsi_ready),
    .out_valid(a_valid[1]), .out_hdr(a_hdr[1]), .out_data(a_data[1]), .out_src(a_src[1]),
    .slot_free(a_free[1]));

  dnet_rob #(.NODE_W(NODE_W), .SEQ_W(SEQ_W), .HW(HW), .BW(BLK_W)) u_rob (
    .clk(clk), .rst_n(rst_n), .wr_valid(a_valid), .wr_src(a_src), .wr_hdr(a_hdr),
    .wr_data(a_data), .slot_free(a_free), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_hdr(rx_hdr), .rx_data(rx_data));

  assign rx_cls     = rx_hdr[0];
  assign rx_long    = rx_hdr[1];
  assign rx_src     = rx_hdr[2 +: NODE_W];
  assign rx_seq     = rx_hdr[SQ_LO +: SEQ_W];
  assign rx_ctrl    = rx_hdr[SQ_LO + SEQ_W +: CTRL_W];
  assign unused_dst = ^rx_hdr;
endmodule

// File: tb/dnet_ni_tb.sv
`timescale 1ns/1ps
module dnet_ni_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic tx_valid = 0, tx_cls = 0, tx_long = 0;
  logic [1:0] tx_dst = 0;
  logic [63:0] tx_ctrl = 0;
  logic [511:0] tx_data = 0;
  logic tx_ready;
  logic [47:0] rqo_flit;  logic rqo_valid; logic rqo_ready = 1;
  logic [127:0] rso_flit; logic rso_valid; logic rso_ready = 1;
  logic [47:0] rqi_flit = 0;  logic rqi_valid = 0; logic rqi_ready;
  logic [127:0] rsi_flit = 0; logic rsi_valid = 0; logic rsi_ready;
  logic rx_valid, rx_cls, rx_long; logic rx_ready = 1;
  logic [1:0] rx_src; logic [3:0] rx_seq; logic [63:0] rx_ctrl; logic [511:0] rx_data;

  dnet_ni u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_cls(tx_cls),
    .tx_long(tx_long), .tx_dst(tx_dst), .tx_ctrl(tx_ctrl), .tx_data(tx_data),
    .rqo_flit(rqo_flit), .rqo_valid(rqo_valid), .rqo_ready(rqo_ready),
    .rso_flit(rso_flit), .rso_valid(rso_valid), .rso_ready(rso_ready),
    .rqi_flit(rqi_flit), .rqi_valid(rqi_valid), .rqi_ready(rqi_ready),
    .rsi_flit(rsi_flit), .rsi_valid(rsi_valid), .rsi_ready(rsi_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_cls(rx_cls), .rx_long(rx_long),
    .rx_src(rx_src), .rx_seq(rx_seq), .rx_ctrl(rx_ctrl), .rx_data(rx_data));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // logs filled at the falling edge
  logic [47:0]  rq_log [64]; int rq_n = 0;
  logic [127:0] rs_log [64]; int rs_n = 0;
  logic [63:0]  dl_ctrl [64]; logic [1:0] dl_src [64]; logic [3:0] dl_seq [64];
  logic dl_cls [64]; logic dl_lng [64]; logic [511:0] dl_data [64]; int dl_n = 0;

  always @(negedge clk) begin
    if (rst_n && rqo_valid && rqo_ready && rq_n < 64) begin rq_log[rq_n] = rqo_flit; rq_n++; end
    if (rst_n && rso_valid && rso_ready && rs_n < 64) begin rs_log[rs_n] = rso_flit; rs_n++; end
    if (rst_n && rx_valid && rx_ready && dl_n < 64) begin
      dl_ctrl[dl_n] = rx_ctrl; dl_src[dl_n] = rx_src; dl_seq[dl_n] = rx_seq;
      dl_cls[dl_n] = rx_cls; dl_lng[dl_n] = rx_long; dl_data[dl_n] = rx_data; dl_n++;
    end
  end

  task automatic chk(string tag, logic [639:0] act, logic [639:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [73:0] mk_hdr(logic c, logic l, logic [1:0] s, logic [1:0] d,
                                         logic [3:0] q, logic [63:0] k);
    logic [73:0] h;
    h = '0;
    h[0] = c; h[1] = l; h[3:2] = s; h[5:4] = d; h[9:6] = q; h[73:10] = k;
    return h;
  endfunction

  task automatic send_tx(logic c, logic l, logic [1:0] d, logic [63:0] k, logic [511:0] blk);
    bit ok;
    tx_cls = c; tx_long = l; tx_dst = d; tx_ctrl = k; tx_data = blk; tx_valid = 1;
    do begin @(negedge clk); ok = tx_ready; @(posedge clk); #1; end while (!ok);
    tx_valid = 0;
  endtask

  // bench-side packet builder and feeder; net 0 narrow, net 1 wide
  task automatic feed(int net, logic c, logic l, logic [1:0] s, logic [3:0] q,
                      logic [63:0] k, logic [511:0] blk);
    logic [1023:0] pk;
    int nf;
    bit ok;
    pk = '0;
    if (net == 0) begin
      pk[73:0] = mk_hdr(c, l, s, 2'd0, q, k);
      pk[96 +: 512] = blk;
      nf = l ? 13 : 2;
    end else begin
      pk[73:0] = mk_hdr(c, l, s, 2'd0, q, k);
      pk[128 +: 512] = blk;
      nf = l ? 5 : 1;
    end
    for (int f = 0; f < nf; f++) begin
      if (net == 0) begin rqi_flit = pk[f*48 +: 48]; rqi_valid = 1; end
      else begin rsi_flit = pk[f*128 +: 128]; rsi_valid = 1; end
      do begin @(negedge clk); ok = (net == 0) ? rqi_ready : rsi_ready; @(posedge clk); #1; end
      while (!ok);
    end
    rqi_valid = 0; rsi_valid = 0;
  endtask

  localparam logic [511:0] BLK_A = {16{32'hA5C3_0F17}} ^ {8{64'h0123_4567_89AB_CDEF}};
  localparam logic [511:0] BLK_B = {16{32'h5EED_B00C}};

  task automatic t_reset();
    @(negedge clk);
    chk("R11 tx_ready", tx_ready, 1);
    chk("R11 rqo_valid", rqo_valid, 0);
    chk("R11 rso_valid", rso_valid, 0);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 rqi_ready", rqi_ready, 1);
    chk("R11 rsi_ready", rsi_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_tx_req();
    logic [95:0] h; logic [623:0] p; int b;
    b = rq_n;
    send_tx(1'b0, 1'b0, 2'd1, 64'hC0FF_EE00_1234_5678, '0);
    cycles(10);
    chk("R3 short req flits", rq_n - b, 2);
    chk("R1 short req not on wide", rs_n, 0);
    h = {rq_log[b+1], rq_log[b]};
    chk("R4 cls", h[0], 0); chk("R4 long", h[1], 0); chk("R4 src", h[3:2], 0);
    chk("R4 dst", h[5:4], 1); chk("R6 seq dst1 first", h[9:6], 0);
    chk("R4 ctrl", h[73:10], 64'hC0FF_EE00_1234_5678); chk("R4 pad", h[95:74], 0);
    b = rq_n;
    send_tx(1'b0, 1'b1, 2'd1, 64'h11, BLK_A);
    cycles(20);
    chk("R3 long req flits", rq_n - b, 13);
    chk("R1 long req not on wide", rs_n, 0);
    for (int f = 0; f < 13; f++) p[f*48 +: 48] = rq_log[b+f];
    chk("R4 long flag", p[1], 1); chk("R6 seq dst1 second", p[9:6], 1);
    chk("R5 narrow block", p[96 +: 512], BLK_A); chk("R5 narrow pad", p[608 +: 16], 0);
  endtask

  task automatic t_tx_rsp();
    logic [639:0] p; int b, qb;
    b = rs_n; qb = rq_n;
    send_tx(1'b1, 1'b0, 2'd1, 64'h22, '0);
    cycles(10);
    chk("R3 short rsp flits", rs_n - b, 1);
    chk("R2 short rsp not on narrow", rq_n - qb, 0);
    chk("R4 rsp cls", rs_log[b][0], 1);
    chk("R6 seq shared across classes", rs_log[b][9:6], 2);
    chk("R4 wide pad", rs_log[b][127:74], 0);
    b = rs_n;
    send_tx(1'b1, 1'b1, 2'd1, 64'h33, BLK_B);
    cycles(12);
    chk("R3 long rsp flits", rs_n - b, 5);
    chk("R2 long rsp not on narrow", rq_n - qb, 0);
    for (int f = 0; f < 5; f++) p[f*128 +: 128] = rs_log[b+f];
    chk("R6 seq dst1 fourth", p[9:6], 3);
    chk("R5 wide block", p[128 +: 512], BLK_B);
    b = rs_n;
    send_tx(1'b1, 1'b0, 2'd2, 64'h44, '0);
    cycles(8);
    chk("R6 per-destination counter", rs_log[b][9:6], 0);
  endtask

  task automatic t_no_interleave();
    logic [47:0] held; int b;
    rqo_ready = 0;
    send_tx(1'b0, 1'b1, 2'd3, 64'h55, BLK_B);
    b = rq_n;
    tx_cls = 0; tx_valid = 1;
    @(negedge clk);
    chk("R7 req blocked during packet", tx_ready, 0);
    tx_cls = 1;
    #0.5;
    chk("R7 rsp still open", tx_ready, 1);
    tx_valid = 0;
    held = rqo_flit;
    cycles(3);
    @(negedge clk);
    chk("R7 flit held", rqo_flit, held);
    chk("R7 valid held", rqo_valid, 1);
    @(posedge clk); #1;
    rqo_ready = 1;
    cycles(20);
    chk("R7 whole packet after release", rq_n - b, 13);
    b = rs_n;
    send_tx(1'b1, 1'b0, 2'd3, 64'h66, '0);
    cycles(8);
    chk("R6 dst3 shared counter", rs_log[b][9:6], 1);
  endtask

  task automatic t_rx_basic();
    int b;
    b = dl_n;
    feed(0, 1'b0, 1'b0, 2'd1, 4'd0, 64'hA1, '0);
    cycles(8);
    chk("R8 one delivered", dl_n - b, 1);
    chk("R8 ctrl", dl_ctrl[b], 64'hA1); chk("R8 src", dl_src[b], 1);
    chk("R8 cls", dl_cls[b], 0); chk("R8 long", dl_lng[b], 0);
    chk("R8 seq", dl_seq[b], 0); chk("R8 short block zero", dl_data[b], 0);
    feed(1, 1'b1, 1'b1, 2'd1, 4'd1, 64'hA2, BLK_A);
    cycles(8);
    chk("R8 long delivered", dl_n - b, 2);
    chk("R8 long block", dl_data[b+1], BLK_A);
    chk("R8 long cls", dl_cls[b+1], 1);
  endtask

  task automatic t_rx_reorder();
    int b;
    b = dl_n;
    feed(1, 1'b1, 1'b1, 2'd2, 4'd1, 64'hB1, BLK_B);
    cycles(15);
    chk("R9 early message held", dl_n - b, 0);
    feed(0, 1'b0, 1'b0, 2'd2, 4'd0, 64'hB0, '0);
    cycles(10);
    chk("R9 both delivered", dl_n - b, 2);
    chk("R9 first is seq0", dl_ctrl[b], 64'hB0);
    chk("R9 second is seq1", dl_ctrl[b+1], 64'hB1);
  endtask

  task automatic t_rx_indep();
    int b;
    b = dl_n;
    feed(0, 1'b0, 1'b0, 2'd3, 4'd1, 64'hC1, '0);
    feed(1, 1'b1, 1'b0, 2'd1, 4'd2, 64'hC2, '0);
    cycles(8);
    chk("R12 other source passes", dl_n - b, 1);
    chk("R12 passing message", dl_ctrl[b], 64'hC2);
    feed(1, 1'b1, 1'b0, 2'd3, 4'd0, 64'hC0, '0);
    cycles(8);
    chk("R12 gap filled count", dl_n - b, 3);
    chk("R12 gap order a", dl_ctrl[b+1], 64'hC0);
    chk("R12 gap order b", dl_ctrl[b+2], 64'hC1);
  endtask

  task automatic t_backpressure();
    int b;
    b = dl_n;
    feed(0, 1'b0, 1'b0, 2'd0, 4'd1, 64'hD1, '0);
    feed(0, 1'b0, 1'b0, 2'd0, 4'd2, 64'hD2, '0);
    cycles(3);
    rqi_flit = mk_hdr(1'b0, 1'b0, 2'd0, 2'd0, 4'd3, 64'hD3)[47:0];
    rqi_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 narrow input stalled", rqi_ready, 0);
      @(posedge clk); #1;
    end
    @(negedge clk);
    chk("R10 wide input open", rsi_ready, 1);
    @(posedge clk); #1;
    rqi_valid = 0;
    chk("R10 nothing delivered yet", dl_n - b, 0);
    feed(1, 1'b1, 1'b0, 2'd0, 4'd0, 64'hD0, '0);
    cycles(8);
    feed(0, 1'b0, 1'b0, 2'd0, 4'd3, 64'hD3, '0);
    cycles(10);
    chk("R10 drained count", dl_n - b, 4);
    chk("R10 order 0", dl_ctrl[b], 64'hD0);
    chk("R10 order 1", dl_ctrl[b+1], 64'hD1);
    chk("R10 order 2", dl_ctrl[b+2], 64'hD2);
    chk("R10 order 3", dl_ctrl[b+3], 64'hD3);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_tx_req();
    t_tx_rsp();
    t_no_interleave();
    t_rx_basic();
    t_rx_reorder();
    t_rx_indep();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule